// File: doc/BRIEF.md
# Zero-Run Split Binary CAM

A small binary content-addressable memory. It holds 8 entries of 10-bit keys and gives back the address of a stored key one cycle after the key is searched. The block does not compare the search key against every entry. Instead, a selector checks the top six key bits (bits 9 down to 4). When all six are zero, the key goes to a direct-indexed table that stores an entry address and a 4-bit tag. Any other key goes to a pair of slice memories. Each slice memory holds one-hot entry vectors, and the two vectors are ANDed together. A 2:1 multiplexer driven by the selector picks which path supplies the hit flag and the address.

Searches use a valid/ready handshake. A search is taken in any cycle where `srch_valid` and `srch_ready` are both high. The result comes out on `res_valid`/`res_hit`/`res_addr` in the next cycle. The result side has no back-pressure: the consumer must take it in that cycle.

Updates also use valid/ready. An update writes a key to an address. It always takes two cycles, whatever the entry count:
- In the first cycle, the key previously held at that address is removed from whichever path holds it.
- In the second cycle, the new key is written into the path its top bits select.

During those two cycles both ready outputs are low. An update and a search may be taken in the same idle cycle. In that case the search sees the contents from before the update.

Top module: `zcam_zr`

## Requirements
- R1: After reset, `res_valid` is 0 and both `srch_ready` and `upd_ready` are 1. Every key searched after reset misses.
- R2: `res_valid` is 1 in exactly the cycle after a search is taken, and 0 in every other cycle.
- R3: A key with bits [9:4] all zero, once written to an address, is found at that address (`res_hit`=1, `res_addr`=address).
- R4: A key with any of bits [9:4] set, once written to an address, is found at that address.
- R5: A search for a key that no entry holds gives `res_hit`=0 and `res_addr`=0. This includes keys that share one slice with a stored key.
- R6: When one key with a nonzero top field is stored at several addresses, a search returns the lowest of those addresses.
- R7: After an update is taken, `upd_ready` (and `srch_ready`) is 0 for exactly two cycles and then returns to 1.
- R8: When a search and an update are taken in the same cycle, the search result reflects the contents from before that update.
- R9: After an address is rewritten, its former key no longer hits at that address. This holds whether the old and new keys use the same path or different paths.
- R10: While an update is in progress, `srch_ready` is 0 and a held `srch_valid` produces no result.
- R11: Whenever `res_valid` is 0, `res_hit` and `res_addr` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| srch_valid | input | 1 | Search key offered |
| srch_ready | output | 1 | Search can be taken (no update in progress) |
| srch_key | input | 10 | Key to search |
| res_valid | output | 1 | Search result present this cycle |
| res_hit | output | 1 | Key found |
| res_addr | output | 3 | Address of the match, 0 on a miss |
| upd_valid | input | 1 | Update offered |
| upd_ready | output | 1 | Update can be taken |
| upd_key | input | 10 | Key to store |
| upd_addr | input | 3 | Entry address to write |

## Verification
A search and an update can be taken in the same idle cycle. This is the one place where the two functions interact.

The bench provokes it by driving `srch_valid` and `upd_valid` together. The searched key is the one currently held at the address being rewritten. The result in the next cycle must still hit at that address. Later searches, after the two busy cycles, must show the old key gone and the new key found.

A second case raises `srch_valid` during the busy cycles. Here the bench judges that no result appears until the update has finished.

// File: rtl/zcam_pkg.sv
package zcam_pkg;
  parameter int unsigned KEY_W_D   = 10;
  parameter int unsigned ZF_W_D    = 6;
  parameter int unsigned ENTRIES_D = 8;

  typedef enum logic [1:0] {
    UPD_IDLE = 2'd0,
    UPD_CLR  = 2'd1,
    UPD_WR   = 2'd2
  } upd_st_e;
endpackage

// File: rtl/zcam_zsel.sv
// Block selector: high when the zero-detect field of the key is all zeros.
module zcam_zsel #(
  parameter int unsigned KEY_W = zcam_pkg::KEY_W_D,
  parameter int unsigned ZF_W  = zcam_pkg::ZF_W_D
) (
  input  logic [ZF_W-1:0] zfield,
  output logic            use_ram
);
  assign use_ram = &(~zfield);
  localparam int unsigned CHK = KEY_W - ZF_W;
  if (CHK == 0) begin : g_bad
    initial $display("zcam_zsel: zero field covers the whole key");
  end
endmodule

// File: rtl/zcam_slice_mem.sv
// One slice memory of the LUT path: each word is a one-hot-per-entry vector.
module zcam_slice_mem #(
  parameter int unsigned IDX_W   = 6,
  parameter int unsigned ENTRIES = zcam_pkg::ENTRIES_D,
  parameter int unsigned AW      = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [IDX_W-1:0]   rd_idx,
  output logic [ENTRIES-1:0] rd_vec,
  input  logic               clr_en,
  input  logic [IDX_W-1:0]   clr_idx,
  input  logic               set_en,
  input  logic [IDX_W-1:0]   set_idx,
  input  logic [AW-1:0]      bit_sel
);
  localparam int unsigned DEPTH = 1 << IDX_W;

  logic [ENTRIES-1:0] mem [DEPTH];

  assign rd_vec = mem[rd_idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (clr_en) begin
      mem[clr_idx][bit_sel] <= 1'b0;
    end else if (set_en) begin
      mem[set_idx][bit_sel] <= 1'b1;
    end
  end
endmodule

// File: rtl/zcam_lut_path.sv
// LUT path: two slice memories ANDed, lowest-address priority encode.
module zcam_lut_path #(
  parameter int unsigned KEY_W   = zcam_pkg::KEY_W_D,
  parameter int unsigned ZF_W    = zcam_pkg::ZF_W_D,
  parameter int unsigned ENTRIES = zcam_pkg::ENTRIES_D,
  parameter int unsigned AW      = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [KEY_W-1:0] s_key,
  output logic             s_hit,
  output logic [AW-1:0]    s_addr,
  input  logic             clr_en,
  input  logic [KEY_W-1:0] clr_key,
  input  logic             wr_en,
  input  logic [KEY_W-1:0] wr_key,
  input  logic [AW-1:0]    u_addr
);
  localparam int unsigned LO_W = KEY_W - ZF_W;
  localparam int unsigned NSL  = 2;

  logic [ENTRIES-1:0] vec [NSL];

  for (genvar g = 0; g < NSL; g++) begin : g_slice
    localparam int unsigned W  = (g == 0) ? ZF_W : LO_W;
    localparam int unsigned LB = (g == 0) ? LO_W : 0;
    zcam_slice_mem #(.IDX_W(W), .ENTRIES(ENTRIES), .AW(AW)) u_mem (
      .clk    (clk),
      .rst_n  (rst_n),
      .rd_idx (s_key[LB +: W]),
      .rd_vec (vec[g]),
      .clr_en (clr_en),
      .clr_idx(clr_key[LB +: W]),
      .set_en (wr_en),
      .set_idx(wr_key[LB +: W]),
      .bit_sel(u_addr)
    );
  end

  logic [ENTRIES-1:0] match;
  assign match = vec[0] & vec[1];

  always_comb begin
    s_addr = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (match[i]) s_addr = AW'(i);
    end
  end
  assign s_hit = |match;
endmodule

// File: rtl/zcam_ram_path.sv
// RAM path: direct-indexed words holding {valid, entry address}, per-entry tags.
module zcam_ram_path #(
  parameter int unsigned KEY_W   = zcam_pkg::KEY_W_D,
  parameter int unsigned ZF_W    = zcam_pkg::ZF_W_D,
  parameter int unsigned ENTRIES = zcam_pkg::ENTRIES_D,
  parameter int unsigned AW      = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [ZF_W-1:0]  s_idx,
  input  logic [KEY_W-ZF_W-1:0] s_tag,
  output logic             s_hit,
  output logic [AW-1:0]    s_addr,
  input  logic             clr_en,
  input  logic [ZF_W-1:0]  clr_idx,
  input  logic             wr_en,
  input  logic [ZF_W-1:0]  wr_idx,
  input  logic [KEY_W-ZF_W-1:0] wr_tag,
  input  logic [AW-1:0]    u_addr
);
  localparam int unsigned LO_W  = KEY_W - ZF_W;
  localparam int unsigned DEPTH = 1 << ZF_W;

  logic [DEPTH-1:0] w_v;
  logic [AW-1:0]    w_a [DEPTH];
  logic [LO_W-1:0]  tag [ENTRIES];

  assign s_addr = w_a[s_idx];
  assign s_hit  = w_v[s_idx] && (tag[w_a[s_idx]] == s_tag);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      w_v <= '0;
      for (int i = 0; i < DEPTH; i++)   w_a[i] <= '0;
      for (int i = 0; i < ENTRIES; i++) tag[i] <= '0;
    end else if (clr_en) begin
      if (w_v[clr_idx] && (w_a[clr_idx] == u_addr)) w_v[clr_idx] <= 1'b0;
    end else if (wr_en) begin
      w_v[wr_idx] <= 1'b1;
      w_a[wr_idx] <= u_addr;
      tag[u_addr] <= wr_tag;
    end
  end
endmodule

// File: rtl/zcam_zr.sv
module zcam_zr #(
  parameter int unsigned KEY_W   = zcam_pkg::KEY_W_D,
  parameter int unsigned ZF_W    = zcam_pkg::ZF_W_D,
  parameter int unsigned ENTRIES = zcam_pkg::ENTRIES_D,
  parameter int unsigned ADDR_W  = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              srch_valid,
  output logic              srch_ready,
  input  logic [KEY_W-1:0]  srch_key,
  output logic              res_valid,
  output logic              res_hit,
  output logic [ADDR_W-1:0] res_addr,
  input  logic              upd_valid,
  output logic              upd_ready,
  input  logic [KEY_W-1:0]  upd_key,
  input  logic [ADDR_W-1:0] upd_addr
);
  import zcam_pkg::*;
  localparam int unsigned LO_W = KEY_W - ZF_W;

  upd_st_e            st;
  logic [KEY_W-1:0]   u_key;
  logic [ADDR_W-1:0]  u_addr;
  logic [ENTRIES-1:0] sh_v;
  logic [KEY_W-1:0]   sh_key [ENTRIES];

  logic busy, s_acc, u_acc;
  assign busy       = (st != UPD_IDLE);
  assign srch_ready = !busy;
  assign upd_ready  = !busy;
  assign s_acc      = srch_valid && srch_ready;
  assign u_acc      = upd_valid && upd_ready;

  logic [KEY_W-1:0] old_key;
  logic             old_v;
  assign old_key = sh_key[u_addr];
  assign old_v   = sh_v[u_addr];

  logic s_ram, o_ram, n_ram;
  zcam_zsel #(.KEY_W(KEY_W), .ZF_W(ZF_W)) u_sel_s (.zfield(srch_key[KEY_W-1 -: ZF_W]), .use_ram(s_ram));
  zcam_zsel #(.KEY_W(KEY_W), .ZF_W(ZF_W)) u_sel_o (.zfield(old_key[KEY_W-1 -: ZF_W]),  .use_ram(o_ram));
  zcam_zsel #(.KEY_W(KEY_W), .ZF_W(ZF_W)) u_sel_n (.zfield(u_key[KEY_W-1 -: ZF_W]),    .use_ram(n_ram));

  logic in_clr, in_wr;
  assign in_clr = (st == UPD_CLR) && old_v;
  assign in_wr  = (st == UPD_WR);

  logic              ram_hit, lut_hit;
  logic [ADDR_W-1:0] ram_addr, lut_addr;

  zcam_ram_path #(.KEY_W(KEY_W), .ZF_W(ZF_W), .ENTRIES(ENTRIES), .AW(ADDR_W)) u_ram (
    .clk    (clk),
    .rst_n  (rst_n),
    .s_idx  (srch_key[ZF_W-1:0]),
    .s_tag  (srch_key[LO_W-1:0]),
    .s_hit  (ram_hit),
    .s_addr (ram_addr),
    .clr_en (in_clr && o_ram),
    .clr_idx(old_key[ZF_W-1:0]),
    .wr_en  (in_wr && n_ram),
    .wr_idx (u_key[ZF_W-1:0]),
    .wr_tag (u_key[LO_W-1:0]),
    .u_addr (u_addr)
  );

  zcam_lut_path #(.KEY_W(KEY_W), .ZF_W(ZF_W), .ENTRIES(ENTRIES), .AW(ADDR_W)) u_lut (
    .clk    (clk),
    .rst_n  (rst_n),
    .s_key  (srch_key),
    .s_hit  (lut_hit),
    .s_addr (lut_addr),
    .clr_en (in_clr && !o_ram),
    .clr_key(old_key),
    .wr_en  (in_wr && !n_ram),
    .wr_key (u_key),
    .u_addr (u_addr)
  );

  logic              m_hit;
  logic [ADDR_W-1:0] m_addr;
  assign m_hit  = s_ram ? ram_hit : lut_hit;
  assign m_addr = s_ram ? ram_addr : lut_addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= UPD_IDLE;
      u_key  <= '0;
      u_addr <= '0;
      sh_v   <= '0;
      for (int i = 0; i < ENTRIES; i++) sh_key[i] <= '0;
    end else begin
      unique case (st)
        UPD_IDLE: if (u_acc) begin
          st     <= UPD_CLR;
          u_key  <= upd_key;
          u_addr <= upd_addr;
        end
        UPD_CLR:  st <= UPD_WR;
        UPD_WR: begin
          st             <= UPD_IDLE;
          sh_v[u_addr]   <= 1'b1;
          sh_key[u_addr] <= u_key;
        end
        default:  st <= UPD_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_hit   <= 1'b0;
      res_addr  <= '0;
    end else begin
      res_valid <= s_acc;
      res_hit   <= s_acc && m_hit;
      res_addr  <= (s_acc && m_hit) ? m_addr : '0;
    end
  end
endmodule

// File: rtl/zcam_zr_chk.sv
module zcam_zr_chk #(
  parameter int unsigned ADDR_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              srch_valid,
  input logic              srch_ready,
  input logic              res_valid,
  input logic              res_hit,
  input logic [ADDR_W-1:0] res_addr,
  input logic              upd_valid,
  input logic              upd_ready
);
  // R2
  res_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (srch_valid && srch_ready) |=> res_valid);

  // R7
  upd_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && upd_ready) |=> !upd_ready ##1 !upd_ready ##1 upd_ready);

  // R10
  stall_no_res_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !srch_ready |=> !res_valid);

  // R5
  miss_addr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_hit) |-> (res_addr == '0));

  // R11
  idle_res_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !res_valid |-> (!res_hit && res_addr == '0));
endmodule

bind zcam_zr zcam_zr_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .srch_valid(srch_valid),
  .srch_ready(srch_ready),
  .res_valid (res_valid),
  .res_hit   (res_hit),
  .res_addr  (res_addr),
  .upd_valid (upd_valid),
  .upd_ready (upd_ready)
);

// File: tb/tb_zcam_zr.sv
module tb_zcam_zr;
  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       srch_valid = 1'b0;
  logic       srch_ready;
  logic [9:0] srch_key = '0;
  logic       res_valid, res_hit;
  logic [2:0] res_addr;
  logic       upd_valid = 1'b0;
  logic       upd_ready;
  logic [9:0] upd_key = '0;
  logic [2:0] upd_addr = '0;

  int n_tests = 0;
  int n_fail  = 0;

  bit       m_v   [8];
  bit [9:0] m_key [8];

  always #(CLK_P/2) clk = ~clk;

  zcam_zr dut (
    .clk(clk), .rst_n(rst_n),
    .srch_valid(srch_valid), .srch_ready(srch_ready), .srch_key(srch_key),
    .res_valid(res_valid), .res_hit(res_hit), .res_addr(res_addr),
    .upd_valid(upd_valid), .upd_ready(upd_ready),
    .upd_key(upd_key), .upd_addr(upd_addr)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic void model_find(input bit [9:0] k, output bit h, output int a);
    h = 0; a = 0;
    for (int i = 7; i >= 0; i--) if (m_v[i] && m_key[i] == k) begin h = 1; a = i; end
  endfunction

  task automatic do_search(input bit [9:0] k, input string req);
    bit eh; int ea;
    model_find(k, eh, ea);
    @(negedge clk);
    srch_valid = 1'b1; srch_key = k;
    chk(srch_ready == 1'b1, "R2", srch_ready, 1);
    @(negedge clk);
    srch_valid = 1'b0;
    chk(res_valid == 1'b1, "R2", res_valid, 1);
    chk(res_hit == eh, req, res_hit, eh);
    chk(res_addr == ea[2:0], req, res_addr, ea);
    @(negedge clk);
    chk(!res_valid && !res_hit && res_addr == 0, "R11", {res_valid, res_hit, res_addr}, 0);
  endtask

  task automatic do_update(input bit [9:0] k, input bit [2:0] a);
    @(negedge clk);
    upd_valid = 1'b1; upd_key = k; upd_addr = a;
    @(negedge clk);
    upd_valid = 1'b0;
    m_v[a] = 1'b1; m_key[a] = k;
    chk(!upd_ready && !srch_ready, "R7", upd_ready, 0);
    @(negedge clk);
    chk(!upd_ready, "R7", upd_ready, 0);
    @(negedge clk);
    chk(upd_ready && srch_ready, "R7", upd_ready, 1);
  endtask

  task automatic t_reset();
    chk(res_valid == 0, "R1", res_valid, 0);
    chk(srch_ready == 1 && upd_ready == 1, "R1", {srch_ready, upd_ready}, 3);
    do_search(10'h000, "R1");
    do_search(10'h2A5, "R1");
  endtask

  task automatic t_ram_path();
    do_update(10'h005, 3'd3);
    do_update(10'h00F, 3'd6);
    do_update(10'h000, 3'd1);
    do_search(10'h005, "R3");
    do_search(10'h00F, "R3");
    do_search(10'h000, "R3");
    do_search(10'h007, "R5");
  endtask

  task automatic t_lut_path();
    do_update(10'h2A5, 3'd0);
    do_update(10'h3FF, 3'd7);
    do_update(10'h010, 3'd4);
    do_search(10'h2A5, "R4");
    do_search(10'h3FF, "R4");
    do_search(10'h010, "R4");
    do_search(10'h2A6, "R5");
    do_search(10'h1A5, "R5");
  endtask

  task automatic t_dup();
    do_update(10'h155, 3'd5);
    do_update(10'h155, 3'd2);
    do_search(10'h155, "R6");
    do_update(10'h0AA, 3'd2);
    do_search(10'h155, "R6");
    do_search(10'h0AA, "R4");
  endtask

  task automatic t_overwrite();
    do_update(10'h123, 3'd3);
    do_search(10'h005, "R9");
    do_search(10'h123, "R9");
    do_update(10'h009, 3'd7);
    do_search(10'h3FF, "R9");
    do_search(10'h009, "R9");
    do_update(10'h00E, 3'd6);
    do_search(10'h00F, "R9");
    do_search(10'h00E, "R9");
  endtask

  task automatic t_collide();
    @(negedge clk);
    srch_valid = 1'b1; srch_key = 10'h010;
    upd_valid  = 1'b1; upd_key  = 10'h00C; upd_addr = 3'd4;
    @(negedge clk);
    srch_valid = 1'b0; upd_valid = 1'b0;
    chk(res_valid && res_hit, "R8", res_hit, 1);
    chk(res_addr == 3'd4, "R8", res_addr, 4);
    chk(!upd_ready, "R7", upd_ready, 0);
    m_v[4] = 1'b1; m_key[4] = 10'h00C;
    @(negedge clk);
    @(negedge clk);
    chk(upd_ready, "R7", upd_ready, 1);
    do_search(10'h010, "R8");
    do_search(10'h00C, "R8");
  endtask

  task automatic t_stall();
    @(negedge clk);
    upd_valid = 1'b1; upd_key = 10'h321; upd_addr = 3'd0;
    @(negedge clk);
    upd_valid = 1'b0;
    m_v[0] = 1'b1; m_key[0] = 10'h321;
    srch_valid = 1'b1; srch_key = 10'h321;
    chk(!srch_ready, "R10", srch_ready, 0);
    @(negedge clk);
    chk(!res_valid, "R10", res_valid, 0);
    chk(!srch_ready, "R10", srch_ready, 0);
    @(negedge clk);
    chk(!res_valid, "R10", res_valid, 0);
    srch_valid = 1'b0;
    do_search(10'h321, "R4");
    do_search(10'h2A5, "R9");
  endtask

  initial begin
    for (int i = 0; i < 8; i++) begin m_v[i] = 0; m_key[i] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_ram_path();
    t_lut_path();
    t_dup();
    t_overwrite();
    t_collide();
    t_stall();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule